// File: doc/BRIEF.md
# Five-Port Mesh Router Node

This block is one node of a two-dimensional on-chip mesh. It has five bidirectional lanes: one toward the attached processing element (Local) and four toward the neighbouring nodes (East, West, North, South). Every lane carries single-word packets of 22 bits. Each packet holds a 3-bit destination column, a 3-bit destination row and a 16-bit payload. The node's own column and row are parameters. Every arriving packet enters a small per-input queue. The head of each queue is steered by dimension-ordered routing: the column is resolved first, then the row.

Each output has its own round-robin arbiter. The arbiter picks at most one of the requesting queue heads per cycle. It produces an enable bit and a 3-bit input select for that output's multiplexer in the crossbar. The crossbar registers the chosen packet, so it leaves one clock after the grant. A packet that loses arbitration stays in its queue and competes again in the next cycle. When a queue holds four packets, the ready signal of that lane drops and the upstream side must hold off.

Top module: `noc_mesh_router`

## Requirements
- R1: Lane index i (0 Local, 1 East, 2 West, 3 North, 4 South) occupies bits [22i+21:22i] of the data buses. Within a packet, bits [21:19] are the destination column, bits [18:16] the destination row and bits [15:0] the payload.
- R2: A packet whose destination column is greater than the node's column leaves on East. A packet whose destination column is smaller leaves on West. The row does not affect this choice.
- R3: When the columns match, a larger destination row goes to North, a smaller one to South, and an equal row goes to Local.
- R4: A delivered packet appears on its output bit for bit as it was accepted.
- R5: An uncontended packet is accepted at clock edge k and shows up with its output valid after edge k+1. The output valid is high only in cycles that follow a grant to that output.
- R6: Each output sends at most one packet per cycle. Packets that lose arbitration wait in their input queue. No packet is lost, and packets from one input to one output keep their order.
- R7: Each output grants among its requesters in round-robin order. The search starts at the input after the one granted last. After reset, input 0 has the first turn.
- R8: Each input queue holds four packets. The lane's ready signal is low exactly while the queue is full.
- R9: A packet offered while its lane's ready signal is low is not accepted and never appears on any output.
- R10: After reset all output valids are low and all ready signals are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per-lane packet offer |
| in_data | input | 110 | Five packed input packets |
| in_ready | output | 5 | Per-lane queue not full |
| out_valid | output | 5 | Per-lane registered packet strobe |
| out_data | output | 110 | Five packed registered output packets |

## Verification
Several checks run on every cycle. Each arbiter's grant must be one-hot or empty and must be a subset of its requests. Under contention, two successive grants of one output must go to different inputs. Queue occupancy must never exceed four, and a queue must never pop while empty. An offer into a full queue must leave occupancy unchanged. Every output strobe must follow a grant by exactly one clock. Other behaviour is only visible in the bench scenarios: the routing decision for each column and row relation, intact payloads, per-input ordering, the exact round-robin turn order after reset, the one-cycle latency, and the loss-free recovery once a lane backs up.

// File: rtl/noc_rt_pkg.sv
package noc_rt_pkg;
  localparam int NUM_PORTS = 5;
  localparam int SEL_W     = 3;

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_EAST  = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_SOUTH = 3'd4
  } port_e;
endpackage

// File: rtl/noc_in_fifo.sv
module noc_in_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, push, take;

  assign full       = (cnt == CW'(DEPTH));
  assign wr_ready   = !full;
  assign push       = wr_valid && !full;
  assign head_valid = (cnt != '0);
  assign take       = pop && head_valid;
  assign head_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (take) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0); // R6
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && !pop) |=> cnt == $past(cnt)); // R9
endmodule

// File: rtl/noc_route_calc.sv
module noc_route_calc
  import noc_rt_pkg::*;
#(
  parameter int CW   = 3,
  parameter int MY_X = 2,
  parameter int MY_Y = 2
) (
  input  logic                 vld,
  input  logic [CW-1:0]        dst_x,
  input  logic [CW-1:0]        dst_y,
  output logic [NUM_PORTS-1:0] req
);
  always_comb begin
    req = '0;
    if (vld) begin
      if (dst_x > CW'(MY_X))      req[P_EAST]  = 1'b1;
      else if (dst_x < CW'(MY_X)) req[P_WEST]  = 1'b1;
      else if (dst_y > CW'(MY_Y)) req[P_NORTH] = 1'b1;
      else if (dst_y < CW'(MY_Y)) req[P_SOUTH] = 1'b1;
      else                        req[P_LOCAL] = 1'b1;
    end
  end
endmodule

// File: rtl/noc_rr_arb.sv
module noc_rr_arb
  import noc_rt_pkg::*;
#(
  parameter int N = NUM_PORTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [SEL_W-1:0] sel,
  output logic             en
);
  logic [SEL_W-1:0] last;
  logic             found;

  always_comb begin
    gnt   = '0;
    sel   = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!found && req[(int'(last) + k) % N]) begin
        found                       = 1'b1;
        gnt[(int'(last) + k) % N]   = 1'b1;
        sel                         = SEL_W'((int'(last) + k) % N);
      end
    end
  end

  assign en = |req;

  always_ff @(posedge clk) begin
    if (rst)     last <= SEL_W'(N - 1);
    else if (en) last <= sel;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R6
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0); // R6
  AST_RR_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (en && $countones(req) > 1) |=> gnt != $past(gnt)); // R7
endmodule

// File: rtl/noc_xbar.sv
module noc_xbar
  import noc_rt_pkg::*;
#(
  parameter int W = 22,
  parameter int N = NUM_PORTS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0][W-1:0]       heads,
  input  logic [N-1:0]              en,
  input  logic [N-1:0][SEL_W-1:0]   sel,
  output logic [N-1:0]              ovalid,
  output logic [N-1:0][W-1:0]       odata
);
  for (genvar o = 0; o < N; o++) begin : g_mux
    always_ff @(posedge clk) begin
      if (rst) ovalid[o] <= 1'b0;
      else     ovalid[o] <= en[o];
    end

    always_ff @(posedge clk) begin
      if (en[o]) odata[o] <= heads[sel[o]];
    end

    AST_OUT_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
      en[o] |=> ovalid[o]); // R5
    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
      !en[o] |=> !ovalid[o]); // R5
  end
endmodule

// File: rtl/noc_mesh_router.sv
module noc_mesh_router
  import noc_rt_pkg::*;
#(
  parameter int COORD_W    = 3,
  parameter int PAY_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [NUM_PORTS-1:0]                      in_valid,
  input  logic [NUM_PORTS*(2*COORD_W+PAY_W)-1:0]    in_data,
  output logic [NUM_PORTS-1:0]                      in_ready,
  output logic [NUM_PORTS-1:0]                      out_valid,
  output logic [NUM_PORTS*(2*COORD_W+PAY_W)-1:0]    out_data
);
  localparam int N     = NUM_PORTS;
  localparam int PKT_W = 2 * COORD_W + PAY_W;
  localparam int X_HI  = PKT_W - 1;
  localparam int Y_HI  = PKT_W - 1 - COORD_W;

  logic [N-1:0][PKT_W-1:0] heads;
  logic [N-1:0]            head_vld;
  logic [N-1:0]            pop;
  logic [N-1:0]            req_in  [N];
  logic [N-1:0]            req_out [N];
  logic [N-1:0]            gnt     [N];
  logic [N-1:0]            xb_en;
  logic [N-1:0][SEL_W-1:0] xb_sel;
  logic [N-1:0][PKT_W-1:0] xb_data;

  for (genvar i = 0; i < N; i++) begin : g_in
    noc_in_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .wr_valid  (in_valid[i]),
      .wr_data   (in_data[i*PKT_W +: PKT_W]),
      .wr_ready  (in_ready[i]),
      .pop       (pop[i]),
      .head_valid(head_vld[i]),
      .head_data (heads[i])
    );

    noc_route_calc #(.CW(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .vld  (head_vld[i]),
      .dst_x(heads[i][X_HI -: COORD_W]),
      .dst_y(heads[i][Y_HI -: COORD_W]),
      .req  (req_in[i])
    );
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_tr
      assign req_out[o][i] = req_in[i][o];
    end

    noc_rr_arb #(.N(N)) u_arb (
      .clk(clk),
      .rst(rst),
      .req(req_out[o]),
      .gnt(gnt[o]),
      .sel(xb_sel[o]),
      .en (xb_en[o])
    );
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < N; o++) pop = pop | gnt[o];
  end

  noc_xbar #(.W(PKT_W), .N(N)) u_xbar (
    .clk   (clk),
    .rst   (rst),
    .heads (heads),
    .en    (xb_en),
    .sel   (xb_sel),
    .ovalid(out_valid),
    .odata (xb_data)
  );

  assign out_data = xb_data;

  AST_POP_HAS_HEAD: assert property (@(posedge clk) disable iff (rst)
    (pop & ~head_vld) == '0); // R6
endmodule

// File: tb/noc_mesh_router_tb.sv
`timescale 1ns/1ps
module noc_mesh_router_tb;
  localparam int N  = 5;
  localparam int PW = 22;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    in_valid = '0;
  logic [N*PW-1:0] in_data  = '0;
  logic [N-1:0]    in_ready;
  logic [N-1:0]    out_valid;
  logic [N*PW-1:0] out_data;

  int total = 0;
  int bad = 0;
  int sent = 0;
  int recv = 0;
  int drops = 0;
  bit finished = 0;
  logic [12:0] seq = '0;
  logic [PW-1:0] pk [N];
  logic [PW-1:0] exp_q [25][$];
  int rr_log[$];

  always #2 clk = ~clk;

  noc_mesh_router u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string rq, input bit ok, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  // R2 R3: own node is column 2, row 2
  function automatic int route(input logic [2:0] x, input logic [2:0] y);
    if (x > 3'd2) return 1;
    if (x < 3'd2) return 2;
    if (y > 3'd2) return 3;
    if (y < 3'd2) return 4;
    return 0;
  endfunction

  task automatic setp(input int i, input logic [2:0] x, input logic [2:0] y);
    pk[i] = {x, y, 3'(i), seq};
    seq = (seq + 1) & 13'h0fff;
  endtask

  // drive at a negedge, hold for one cycle
  task automatic fire(input logic [N-1:0] mask);
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        in_valid[i] = 1'b1;
        if (in_ready[i]) begin
          in_data[i*PW +: PW] = pk[i];
          exp_q[route(pk[i][21:19], pk[i][18:16])*5 + i].push_back(pk[i]);
          sent++;
        end else begin
          in_data[i*PW +: PW] = pk[i] | 22'h1000; // poison, R9
          drops++;
        end
      end
    end
    @(negedge clk);
    in_valid = '0;
  endtask

  // scoreboard monitor: R4 R6
  logic [PW-1:0] got;
  int src;
  always @(negedge clk) begin
    if (!rst) begin
      for (int o = 0; o < N; o++) begin
        if (out_valid[o]) begin
          got = out_data[o*PW +: PW];
          src = int'(got[15:13]);
          recv++;
          if (o == 0) rr_log.push_back(src);
          if (src > 4 || exp_q[o*5 + src].size() == 0) begin
            chk("R9 unexpected packet", 1'b0, int'(got), o);
          end else begin
            chk("R4 packet content", got == exp_q[o*5 + src][0], int'(got),
                int'(exp_q[o*5 + src][0]));
            void'(exp_q[o*5 + src].pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk("watchdog", 1'b0, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int empty_all;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 out_valid after reset", out_valid == '0, out_valid, 0);
    chk("R10 in_ready after reset", in_ready == 5'h1f, in_ready, 5'h1f);

    // R7: inputs 1,2,3 to Local together, then 1 and 3
    setp(1, 3'd2, 3'd2); setp(2, 3'd2, 3'd2); setp(3, 3'd2, 3'd2);
    fire(5'b01110);
    repeat (6) @(negedge clk);
    setp(1, 3'd2, 3'd2); setp(3, 3'd2, 3'd2);
    fire(5'b01010);
    repeat (6) @(negedge clk);
    chk("R7 grant count", rr_log.size() == 5, rr_log.size(), 5);
    if (rr_log.size() == 5) begin
      chk("R7 turn 1", rr_log[0] == 1, rr_log[0], 1);
      chk("R7 turn 2", rr_log[1] == 2, rr_log[1], 2);
      chk("R7 turn 3", rr_log[2] == 3, rr_log[2], 3);
      chk("R7 turn 4", rr_log[3] == 1, rr_log[3], 1);
      chk("R7 turn 5", rr_log[4] == 3, rr_log[4], 3);
    end

    // R5: single packet West lane -> East, latency
    setp(2, 3'd5, 3'd2);
    fire(5'b00100);
    chk("R5 not yet valid", out_valid[1] == 1'b0, out_valid[1], 0);
    @(negedge clk);
    chk("R5 valid one clock later", out_valid[1] == 1'b1, out_valid[1], 1);
    chk("R1 East lane data", out_data[1*PW +: PW] == pk[2], int'(out_data[1*PW +: PW]), int'(pk[2]));
    @(negedge clk);
    chk("R5 valid drops without grant", out_valid == '0, out_valid, 0);

    // R2 R3: permutation patterns
    setp(0, 3'd5, 3'd2); setp(1, 3'd0, 3'd3); setp(2, 3'd2, 3'd7);
    setp(3, 3'd2, 3'd0); setp(4, 3'd2, 3'd2);
    fire(5'b11111);
    chk("R2 R3 all outputs busy", out_valid == '0, out_valid, 0);
    @(negedge clk);
    chk("R2 R3 five outputs at once", out_valid == 5'h1f, out_valid, 5'h1f);
    setp(0, 3'd2, 3'd2); setp(1, 3'd7, 3'd7); setp(2, 3'd1, 3'd6);
    setp(3, 3'd2, 3'd3); setp(4, 3'd2, 3'd1);
    fire(5'b11111);
    @(negedge clk);
    chk("R2 R3 second pattern", out_valid == 5'h1f, out_valid, 5'h1f);
    // R6: all five to West
    for (int i = 0; i < N; i++) setp(i, 3'd0, 3'(i));
    fire(5'b11111);
    repeat (8) @(negedge clk);

    // R8 R9: two lanes stream into East
    for (int c = 0; c < 16; c++) begin
      setp(3, 3'd4, 3'd1); setp(4, 3'd6, 3'd5);
      fire(5'b11000);
    end
    chk("R8 ready dropped on full queue", drops > 0, drops, 1);
    repeat (40) @(negedge clk);

    empty_all = 1;
    for (int k = 0; k < 25; k++) if (exp_q[k].size() != 0) empty_all = 0;
    chk("R6 nothing left undelivered", empty_all == 1, empty_all, 1);
    chk("R9 delivered equals accepted", recv == sent, recv, sent);
    chk("R8 ready restored", in_ready == 5'h1f, in_ready, 5'h1f);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule